// File: doc/BRIEF.md
# Programmable Read-Latency Window Scheduler

This block sits beside an SDRAM read path and decides when returned read data is valid. A mode-register write loads three settings: the read latency in clocks, the write-recovery time in clocks, and the exit type for active power-down. Each accepted READ opens a data-valid window. The window starts exactly the programmed latency after the clock edge that registered the READ. It lasts for one four-beat burst, which is two clocks with two beats per clock.

A controller uses `dvalid` and `beat_idx` to capture read data. It uses `wr_clks` to space writes ahead of precharge, and `pd_slow` to choose its power-down exit timing. Reserved encodings in the latency or recovery fields raise `cfg_bad`. A READ that cannot be honoured is refused, and the refusal shows on `rd_reject`. A READ is refused when the latency setting is reserved, or when it follows an accepted READ by only one clock. A combinational checker compares a supplied tWR/tCK pair against the programmed recovery value.

Top module: `rdlat_sched`

## Requirements
- R1: After reset the block reports `cl_clks`=3, `wr_clks`=2, `pd_slow`=0, `cfg_bad`=0, `dvalid`=0 and `rd_reject`=0. READs are then scheduled with a latency of 3.
- R2: On a mode write, `mode_word[6:4]` becomes the read latency and appears unchanged on `cl_clks`. Only values 3, 4, 5 and 6 are legal.
- R3: On a mode write, the recovery field `mode_word[11:9]` is stored. Codes 1 to 5 give `wr_clks` = code+1, that is 2 to 6 clocks. Codes 0, 6 and 7 are reserved and give `wr_clks`=0.
- R4: `cfg_bad` is 1 exactly when the stored latency code is 0, 1, 2 or 7, or when the stored recovery code is reserved. All other mode bits (3:0, 8:7) are ignored.
- R5: `mode_word[12]` sets `pd_slow`, where 1 selects slow exit and 0 selects fast exit. It has no effect on read windows. No setting changes while `mode_we` is 0, whatever `mode_word` carries.
- R6: An accepted READ registered at edge E drives `dvalid` high in the clock that follows edge E+CL with `beat_idx`=0 (beats 0 and 1). It then drives `dvalid` high in the clock that follows edge E+CL+1 with `beat_idx`=2 (beats 2 and 3). `dvalid` is low at all other times when no other READ is pending.
- R7: READs spaced two clocks apart produce back-to-back windows with no gap and no overlap.
- R8: A READ registered while the stored latency code is reserved opens no window. `rd_reject` is high in the clock after that edge.
- R9: A READ registered one clock after an accepted READ is refused with `rd_reject` and opens no window. The earlier window is unaffected.
- R10: `wr_mismatch` is 1 when `tck_ns` is 0, when `wr_clks` is 0, or when ceil(`twr_ns`/`tck_ns`) differs from `wr_clks`. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_we | input | 1 | Mode-register write strobe |
| mode_word | input | 13 | Mode word: latency [6:4], recovery [11:9], power-down exit [12] |
| rd_cmd | input | 1 | READ command, registered on the rising edge |
| twr_ns | input | TIME_W | Write-recovery time in ns for the check |
| tck_ns | input | TIME_W | Clock period in ns for the check |
| dvalid | output | 1 | Read data valid in this clock |
| beat_idx | output | BEAT_W | First beat carried in this clock (0 or 2) |
| rd_reject | output | 1 | The READ of the previous edge was refused |
| cl_clks | output | 3 | Stored read latency |
| wr_clks | output | 3 | Decoded write recovery in clocks, 0 when reserved |
| pd_slow | output | 1 | Active power-down exit type, 1 for slow exit |
| cfg_bad | output | 1 | A stored field holds a reserved code |
| wr_mismatch | output | 1 | tWR/tCK disagrees with the programmed recovery |

## Verification
The hardest cases to reach from the ports are a READ that lands one clock after an accepted READ, and a READ issued under a reserved latency code. Both need the right read spacing and the right stored setting at the same time. The bench sweeps all eight latency codes. Under each code it plays a fixed set of READ spacings (single, two apart, adjacent, three apart, a train of four, a triple), so every window, collision and refusal is compared cycle by cycle with an arithmetic model. A second sweep programs every recovery code and covers every tWR/tCK pair in a small grid.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;
  localparam int MODE_W  = 13;
  localparam int CL_LSB  = 4;
  localparam int WR_LSB  = 9;
  localparam int PD_BIT  = 12;
  localparam logic [2:0] CL_RST_CODE = 3'd3;
  localparam logic [2:0] WR_RST_CODE = 3'd1;

  function automatic logic cl_legal(input logic [2:0] code);
    return (code >= 3'd3) && (code <= 3'd6);
  endfunction

  function automatic logic [2:0] wr_decode(input logic [2:0] code);
    return ((code >= 3'd1) && (code <= 3'd5)) ? code + 3'd1 : 3'd0;
  endfunction
endpackage

// File: rtl/rdlat_mode_reg.sv
module rdlat_mode_reg
  import rdlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_word,
  output logic [2:0]        cl_clks,
  output logic [2:0]        wr_clks,
  output logic              pd_slow,
  output logic              cl_bad,
  output logic              cfg_bad
);
  logic [2:0] cl_q, cl_d;
  logic [2:0] wrc_q, wrc_d;
  logic       pd_q, pd_d;

  always_comb begin
    cl_d  = mode_word[CL_LSB +: 3];
    wrc_d = mode_word[WR_LSB +: 3];
    pd_d  = mode_word[PD_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q  <= CL_RST_CODE;
      wrc_q <= WR_RST_CODE;
      pd_q  <= 1'b0;
    end else if (mode_we) begin
      cl_q  <= cl_d;
      wrc_q <= wrc_d;
      pd_q  <= pd_d;
    end
  end

  assign cl_clks = cl_q;
  assign wr_clks = wr_decode(wrc_q);
  assign pd_slow = pd_q;
  assign cl_bad  = !cl_legal(cl_q);
  assign cfg_bad = cl_bad | (wr_clks == 3'd0);
endmodule

// File: rtl/rdlat_read_pipe.sv
module rdlat_read_pipe #(
  parameter  int CL_MAX     = 6,
  parameter  int BURST_CLKS = 2,
  localparam int DEPTH      = CL_MAX + BURST_CLKS,
  localparam int BEAT_W     = $clog2(2 * BURST_CLKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic              cl_bad,
  input  logic [2:0]        cl_clks,
  output logic              dvalid,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              rd_reject
);
  logic [DEPTH-1:0] pipe_q, pipe_d;
  logic             rej_q, rej_d;
  logic             accept;

  always_comb begin
    accept = rd_cmd && !cl_bad && !pipe_q[0];
    pipe_d = {pipe_q[DEPTH-2:0], accept};
    rej_d  = rd_cmd && !accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      rej_q  <= 1'b0;
    end else begin
      pipe_q <= pipe_d;
      rej_q  <= rej_d;
    end
  end

  always_comb begin
    dvalid   = 1'b0;
    beat_idx = '0;
    for (int j = 0; j < BURST_CLKS; j++) begin
      if ((int'(cl_clks) + j) < DEPTH) begin
        if (pipe_q[int'(cl_clks) + j]) begin
          dvalid   = 1'b1;
          beat_idx = BEAT_W'(2 * j);
        end
      end
    end
  end

  assign rd_reject = rej_q;
endmodule

// File: rtl/rdlat_wr_check.sv
module rdlat_wr_check #(
  parameter int TIME_W = 8
) (
  input  logic [TIME_W-1:0] twr_ns,
  input  logic [TIME_W-1:0] tck_ns,
  input  logic [2:0]        wr_clks,
  output logic              wr_mismatch
);
  logic [TIME_W:0] num;
  logic [TIME_W:0] quo;

  always_comb begin
    num = '0;
    quo = '0;
    if (tck_ns == '0 || wr_clks == 3'd0) begin
      wr_mismatch = 1'b1;
    end else begin
      num = {1'b0, twr_ns} + {1'b0, tck_ns} - 1'b1;
      quo = num / {1'b0, tck_ns};
      wr_mismatch = (quo != (TIME_W+1)'(wr_clks));
    end
  end
endmodule

// File: rtl/rdlat_sched.sv
module rdlat_sched
  import rdlat_pkg::*;
#(
  parameter  int CL_MAX     = 6,
  parameter  int BURST_CLKS = 2,
  parameter  int TIME_W     = 8,
  localparam int BEAT_W     = $clog2(2 * BURST_CLKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              rd_cmd,
  input  logic [TIME_W-1:0] twr_ns,
  input  logic [TIME_W-1:0] tck_ns,
  output logic              dvalid,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              rd_reject,
  output logic [2:0]        cl_clks,
  output logic [2:0]        wr_clks,
  output logic              pd_slow,
  output logic              cfg_bad,
  output logic              wr_mismatch
);
  logic [1:0] rst_sync_q;
  logic       rst_ok_n;
  logic       cl_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok_n = rst_sync_q[1];

  rdlat_mode_reg u_mode (
    .clk(clk), .rst_n(rst_ok_n), .mode_we(mode_we), .mode_word(mode_word),
    .cl_clks(cl_clks), .wr_clks(wr_clks), .pd_slow(pd_slow),
    .cl_bad(cl_bad), .cfg_bad(cfg_bad)
  );

  rdlat_read_pipe #(.CL_MAX(CL_MAX), .BURST_CLKS(BURST_CLKS)) u_pipe (
    .clk(clk), .rst_n(rst_ok_n), .rd_cmd(rd_cmd), .cl_bad(cl_bad),
    .cl_clks(cl_clks), .dvalid(dvalid), .beat_idx(beat_idx), .rd_reject(rd_reject)
  );

  rdlat_wr_check #(.TIME_W(TIME_W)) u_wrchk (
    .twr_ns(twr_ns), .tck_ns(tck_ns), .wr_clks(wr_clks), .wr_mismatch(wr_mismatch)
  );
endmodule

// File: rtl/rdlat_sched_chk.sv
module rdlat_sched_chk #(
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic              mode_we,
  input logic              rd_cmd,
  input logic              cl_bad,
  input logic              dvalid,
  input logic [BEAT_W-1:0] beat_idx,
  input logic              rd_reject,
  input logic [2:0]        cl_clks,
  input logic [2:0]        wr_clks,
  input logic              pd_slow,
  input logic              wr_mismatch
);
  AST_BAD_CL_REFUSED: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rd_cmd && cl_bad |=> rd_reject); // R8

  AST_WIN_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_ok_n)
    dvalid && beat_idx == '0 && !mode_we |=> dvalid && beat_idx == BEAT_W'(2)); // R6

  AST_WIN_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_ok_n)
    dvalid && beat_idx == BEAT_W'(2) && !mode_we |=> !dvalid || beat_idx == '0); // R7

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !mode_we |=> $stable(cl_clks) && $stable(wr_clks) && $stable(pd_slow)); // R5

  AST_WR_RESERVED_MISMATCH: assert property (@(posedge clk) disable iff (!rst_ok_n)
    wr_clks == 3'd0 |-> wr_mismatch); // R10
endmodule

bind rdlat_sched rdlat_sched_chk #(.BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_ok_n(rst_ok_n), .mode_we(mode_we), .rd_cmd(rd_cmd),
  .cl_bad(cl_bad), .dvalid(dvalid), .beat_idx(beat_idx), .rd_reject(rd_reject),
  .cl_clks(cl_clks), .wr_clks(wr_clks), .pd_slow(pd_slow), .wr_mismatch(wr_mismatch)
);

// File: tb/rdlat_sched_test.sv
`timescale 1ns/1ps
module rdlat_sched_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_we;
  logic [12:0] mode_word;
  logic        rd_cmd;
  logic [7:0]  twr_ns, tck_ns;
  logic        dvalid;
  logic [1:0]  beat_idx;
  logic        rd_reject;
  logic [2:0]  cl_clks, wr_clks;
  logic        pd_slow, cfg_bad, wr_mismatch;

  always #2.5 clk = ~clk;

  rdlat_sched uut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_word(mode_word),
    .rd_cmd(rd_cmd), .twr_ns(twr_ns), .tck_ns(tck_ns), .dvalid(dvalid),
    .beat_idx(beat_idx), .rd_reject(rd_reject), .cl_clks(cl_clks),
    .wr_clks(wr_clks), .pd_slow(pd_slow), .cfg_bad(cfg_bad), .wr_mismatch(wr_mismatch)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] hist;
  int cur_cl;
  bit cl_ok;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock; inputs set after a falling edge, outputs checked at the next falling edge
  task automatic tick(input logic rd);
    logic acc;
    logic exp_dv;
    logic collide;
    rd_cmd = rd;
    @(posedge clk);
    collide = hist[0];
    acc = rd && cl_ok && !hist[0];
    hist = {hist[14:0], acc};
    @(negedge clk);
    rd_cmd = 1'b0;
    exp_dv = (cur_cl >= 3 && cur_cl <= 6) ? (hist[cur_cl] | hist[cur_cl+1]) : 1'b0;
    chk("R6/R7 dvalid", int'(dvalid), int'(exp_dv));
    if (exp_dv) chk("R6 beat_idx", int'(beat_idx), hist[cur_cl] ? 0 : 2);
    if (rd && !cl_ok)      chk("R8 reject", int'(rd_reject), 1);
    else if (rd && collide) chk("R9 reject", int'(rd_reject), 1);
    else                   chk("R6 no reject", int'(rd_reject), 0);
  endtask

  task automatic mode_wr(input logic [12:0] w);
    int exp_wr;
    mode_we = 1'b1;
    mode_word = w;
    @(posedge clk);
    hist = {hist[14:0], 1'b0};
    @(negedge clk);
    mode_we = 1'b0;
    cur_cl = int'(w[6:4]);
    cl_ok = (cur_cl >= 3 && cur_cl <= 6);
    exp_wr = (w[11:9] >= 1 && w[11:9] <= 5) ? int'(w[11:9]) + 1 : 0;
    chk("R2 cl_clks", int'(cl_clks), cur_cl);
    chk("R3 wr_clks", int'(wr_clks), exp_wr);
    chk("R4 cfg_bad", int'(cfg_bad), (!cl_ok || exp_wr == 0) ? 1 : 0);
    chk("R5 pd_slow", int'(pd_slow), int'(w[12]));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [6];
    pats[0] = 16'b0000000000000001;
    pats[1] = 16'b0000000000000101;
    pats[2] = 16'b0000000000000011;
    pats[3] = 16'b0000000000001001;
    pats[4] = 16'b0000000001010101;
    pats[5] = 16'b0000000000000111;
    rst_n = 1'b0; mode_we = 1'b0; mode_word = '0; rd_cmd = 1'b0;
    twr_ns = '0; tck_ns = '0;
    hist = '0; cur_cl = 3; cl_ok = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cl_clks", int'(cl_clks), 3);
    chk("R1 wr_clks", int'(wr_clks), 2);
    chk("R1 pd_slow", int'(pd_slow), 0);
    chk("R1 cfg_bad", int'(cfg_bad), 0);
    chk("R1 dvalid", int'(dvalid), 0);
    chk("R1 rd_reject", int'(rd_reject), 0);
    // R1 default latency of 3 in use
    for (int b = 0; b < 16; b++) tick(pats[4][b]);
    repeat (10) tick(1'b0);

    // latency sweep over every code, each with all read spacings
    for (int code = 0; code < 8; code++) begin
      mode_wr({1'(code & 1), 3'd1, 2'b11, 3'(code), 4'b1010});
      for (int p = 0; p < 6; p++) begin
        for (int b = 0; b < 16; b++) tick(pats[p][b]);
        repeat (10) tick(1'b0);
      end
    end

    // R5 settings hold without the strobe
    mode_wr(13'b1_011_00_100_0000);
    mode_word = 13'h1FFF;
    repeat (3) tick(1'b0);
    chk("R5 hold cl", int'(cl_clks), 4);
    chk("R5 hold wr", int'(wr_clks), 4);
    chk("R5 hold pd", int'(pd_slow), 1);
    mode_wr(13'b0_011_00_100_0000);

    // recovery sweep with tWR/tCK check
    for (int wc = 0; wc < 8; wc++) begin
      int exp_wr;
      mode_wr({1'b0, 3'(wc), 2'b00, 3'd5, 4'b0000});
      exp_wr = (wc >= 1 && wc <= 5) ? wc + 1 : 0;
      for (int tck = 0; tck < 10; tck++) begin
        for (int twr = 0; twr < 32; twr++) begin
          int exp_mm;
          tck_ns = 8'(tck);
          twr_ns = 8'(twr);
          #1;
          if (tck == 0 || exp_wr == 0) exp_mm = 1;
          else exp_mm = (((twr + tck - 1) / tck) != exp_wr) ? 1 : 0;
          chk("R10 wr_mismatch", int'(wr_mismatch), exp_mm);
        end
      end
      @(negedge clk);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule